// File: doc/BRIEF.md
# Snooping Invalidate Coherence Controller

This block keeps one private cache coherent with its peers on a single shared bus. Each line is in one of three states: Invalid, Shared (clean, read-only, possibly held by other caches too) or Modified (dirty, read-write, held by no other cache). A small direct-mapped tag store records the tag and state of every line. The block does not hold line data. Processor read and write requests enter through a valid/ready port. A hit finishes at once. A miss, or a write that needs ownership, becomes a bus transaction that waits for the arbiter's grant and for the responder's completion strobe.

The controller also watches the transactions that other caches place on the bus and acts on its own copies. A clean copy is dropped when another cache reads for ownership or invalidates. A dirty copy raises a dirty-intervene flag, which tells memory to stay silent because this cache supplies the line. A dirty victim is written back before its slot is refilled. The bus command is chosen at grant time, so a line lost to a snoop while a request waits is handled correctly.

Top module: `coh_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid, so the first read of any address issues a bus transaction. While reset is held, cpuReady, busReq, busActive and snpDirty are 0.
- R2: A read of a line held Shared or Modified, or a write of a line held Modified, raises cpuReady in the same cycle that cpuValid is seen, with no bus request.
- R3: A read miss issues bus command 0 (read-line) on busAddr = cpuAddr[ADDR_W-1:OFF_W] and leaves the line Shared. OFF_W is log2(LINE_BYTES), and the set index is the low log2(NUM_LINES) bits of that line address.
- R4: A write to an Invalid line issues bus command 1 (read-for-ownership) and leaves the line Modified.
- R5: A write to a Shared line issues bus command 2 (invalidate) and leaves the line Modified.
- R6: A transaction starts (busActive) only in the cycle after a cycle with busGnt high. busReq stays high and busCmd and busAddr stay stable until busDone. While the grant is withheld, busActive stays 0.
- R7: A snoop read (command 0) that hits a Modified line raises snpDirty in the next cycle and moves the line to Shared.
- R8: A snoop read-for-ownership (command 1) that hits a Modified line raises snpDirty in the next cycle and invalidates the line.
- R9: A snoop read-for-ownership or invalidate (command 2) that hits a Shared line invalidates it without raising snpDirty. A snoop read that hits a Shared line leaves it unchanged.
- R10: A miss whose slot holds a different Modified line first writes that line back with bus command 3 on the victim's line address, then issues the refill.
- R11: A write that waits for the grant to upgrade a Shared line, and loses the line to a snoop before the grant, issues a read-for-ownership instead of an invalidate.
- R12: A dirty victim that a snoop downgrades or removes before the write-back grant is not written back, and the refill request is issued directly.
- R13: Snoops with a non-matching tag, or with command 3, change no state and raise no snpDirty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuValid | input | 1 | Processor request valid, held until cpuReady |
| cpuWrite | input | 1 | 1 for write, 0 for read |
| cpuAddr | input | ADDR_W | Processor byte address |
| cpuReady | output | 1 | Request completes in this cycle |
| busReq | output | 1 | Request for the shared bus |
| busGnt | input | 1 | Bus grant from the arbiter |
| busActive | output | 1 | A transaction from this cache is on the bus |
| busCmd | output | 2 | 0 read-line, 1 read-for-ownership, 2 invalidate, 3 write-back |
| busAddr | output | ADDR_W-log2(LINE_BYTES) | Line address of the transaction |
| busDone | input | 1 | Responder finished the current transaction |
| snpValid | input | 1 | Another cache's transaction is visible for snooping |
| snpCmd | input | 2 | Command of the snooped transaction, same coding as busCmd |
| snpLine | input | ADDR_W-log2(LINE_BYTES) | Line address of the snooped transaction |
| snpDirty | output | 1 | Dirty-intervene: this cache supplies the line, memory stays silent |

## Verification
A wrong line state never shows directly. It shows at the next access to that line. A state that is too strong (Modified or Shared where Invalid is correct) makes a later access hit with no bus request. A state that is too weak causes an extra read-line, invalidate or write-back in the scoreboard's transaction stream. Snoop state errors also show one cycle after the snoop, on snpDirty. The bench therefore follows each state change with a probing access and compares every bus command and line address in order. The races between grant and snoop are driven by holding the grant back.

// File: rtl/coh_pkg.sv
`timescale 1ns/1ps
package coh_pkg;
  typedef enum logic [1:0] {
    ST_I = 2'd0,
    ST_S = 2'd1,
    ST_M = 2'd2
  } lineState_e;

  typedef enum logic [1:0] {
    CMD_RD  = 2'd0,
    CMD_RDX = 2'd1,
    CMD_UPG = 2'd2,
    CMD_WB  = 2'd3
  } busCmd_e;

  // strobes from the control FSM to the tag/state datapath
  typedef struct packed {
    logic       fillEn;
    lineState_e fillState;
    logic       dropVictim;
    logic       selVictim;
  } ctrlStrobe_t;
endpackage

// File: rtl/coh_datapath.sv
`timescale 1ns/1ps
module coh_datapath
  import coh_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int NUM_LINES  = 16,
  localparam int OFF_W  = $clog2(LINE_BYTES),
  localparam int IDX_W  = $clog2(NUM_LINES),
  localparam int LINE_W = ADDR_W - OFF_W,
  localparam int TAG_W  = LINE_W - IDX_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  ctrlStrobe_t       strobe,
  input  logic              snpValid,
  input  logic [1:0]        snpCmd,
  input  logic [LINE_W-1:0] snpLine,
  output lineState_e        lkState,
  output lineState_e        vicState,
  output logic [LINE_W-1:0] busLine,
  output logic              snpDirty
);
  lineState_e       stateMem [NUM_LINES];
  logic [TAG_W-1:0] tagMem   [NUM_LINES];

  logic [LINE_W-1:0] cpuLine;
  logic [IDX_W-1:0]  cpuIdx;
  logic [TAG_W-1:0]  cpuTag;
  logic              unusedOffset;

  assign cpuLine      = cpuAddr[ADDR_W-1:OFF_W];
  assign cpuIdx       = cpuLine[IDX_W-1:0];
  assign cpuTag       = cpuLine[LINE_W-1:IDX_W];
  assign unusedOffset = ^cpuAddr[OFF_W-1:0];

  // processor-side lookup: slot state, and state of the addressed line
  assign vicState = stateMem[cpuIdx];
  assign lkState  = (tagMem[cpuIdx] == cpuTag) ? stateMem[cpuIdx] : ST_I;
  assign busLine  = strobe.selVictim ? {tagMem[cpuIdx], cpuIdx} : cpuLine;

  // snoop-side lookup
  logic [IDX_W-1:0] snpIdx;
  logic [TAG_W-1:0] snpTag;
  lineState_e       snpSt;
  lineState_e       snpNext;
  logic             snpHit;
  logic             snpApply;
  logic             dirtyNext;
  logic             localUpd;

  assign snpIdx   = snpLine[IDX_W-1:0];
  assign snpTag   = snpLine[LINE_W-1:IDX_W];
  assign snpSt    = stateMem[snpIdx];
  assign snpHit   = snpValid && (tagMem[snpIdx] == snpTag) && (snpSt != ST_I);
  assign localUpd = strobe.fillEn || strobe.dropVictim;
  // a local update to the same slot in the same cycle takes priority
  assign snpApply = snpHit && !(localUpd && (snpIdx == cpuIdx));

  always_comb begin
    snpNext   = snpSt;
    dirtyNext = 1'b0;
    if (snpApply) begin
      case (busCmd_e'(snpCmd))
        CMD_RD: begin
          if (snpSt == ST_M) begin
            snpNext   = ST_S;
            dirtyNext = 1'b1;
          end
        end
        CMD_RDX: begin
          dirtyNext = (snpSt == ST_M);
          snpNext   = ST_I;
        end
        CMD_UPG: snpNext = ST_I;
        default: snpNext = snpSt;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_LINES; i++) begin
        stateMem[i] <= ST_I;
        tagMem[i]   <= '0;
      end
      snpDirty <= 1'b0;
    end else begin
      snpDirty <= dirtyNext;
      if (snpApply) begin
        stateMem[snpIdx] <= snpNext;
      end
      if (strobe.fillEn) begin
        stateMem[cpuIdx] <= strobe.fillState;
        tagMem[cpuIdx]   <= cpuTag;
      end else if (strobe.dropVictim) begin
        stateMem[cpuIdx] <= ST_I;
      end
    end
  end
endmodule

// File: rtl/coh_control.sv
`timescale 1ns/1ps
module coh_control
  import coh_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cpuValid,
  input  logic        cpuWrite,
  input  lineState_e  lkState,
  input  lineState_e  vicState,
  input  logic        busGnt,
  input  logic        busDone,
  output logic        cpuReady,
  output logic        busReq,
  output logic        busActive,
  output busCmd_e     busCmd,
  output ctrlStrobe_t strobe
);
  typedef enum logic [2:0] {
    C_IDLE  = 3'd0,
    C_WBREQ = 3'd1,
    C_WBBUS = 3'd2,
    C_REQ   = 3'd3,
    C_BUS   = 3'd4
  } ctlState_e;

  ctlState_e state, nextState;
  busCmd_e   cmdQ, cmdNext;
  logic      canHit;

  assign canHit = (lkState == ST_M) || ((lkState == ST_S) && !cpuWrite);

  always_comb begin
    nextState = state;
    cmdNext   = cmdQ;
    cpuReady  = 1'b0;
    busReq    = 1'b0;
    busActive = 1'b0;
    strobe    = '0;
    case (state)
      C_IDLE: begin
        if (cpuValid) begin
          if (canHit) begin
            cpuReady = 1'b1;
          end else if ((vicState == ST_M) && (lkState == ST_I)) begin
            nextState = C_WBREQ;
          end else begin
            nextState = C_REQ;
          end
        end
      end
      C_WBREQ: begin
        if (vicState != ST_M) begin
          // a snoop took the dirty victim: nothing left to write back
          nextState = C_REQ;
        end else begin
          busReq = 1'b1;
          if (busGnt) begin
            nextState = C_WBBUS;
          end
        end
      end
      C_WBBUS: begin
        busReq           = 1'b1;
        busActive        = 1'b1;
        strobe.selVictim = 1'b1;
        if (busDone) begin
          strobe.dropVictim = 1'b1;
          nextState         = C_REQ;
        end
      end
      C_REQ: begin
        busReq = 1'b1;
        if (busGnt) begin
          // command is fixed from the line state at grant time
          if (!cpuWrite) begin
            cmdNext = CMD_RD;
          end else if (lkState == ST_S) begin
            cmdNext = CMD_UPG;
          end else begin
            cmdNext = CMD_RDX;
          end
          nextState = C_BUS;
        end
      end
      C_BUS: begin
        busReq    = 1'b1;
        busActive = 1'b1;
        if (busDone) begin
          strobe.fillEn    = 1'b1;
          strobe.fillState = (cmdQ == CMD_RD) ? ST_S : ST_M;
          cpuReady         = 1'b1;
          nextState        = C_IDLE;
        end
      end
      default: nextState = C_IDLE;
    endcase
  end

  assign busCmd = (state == C_WBBUS) ? CMD_WB : cmdQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= C_IDLE;
      cmdQ  <= CMD_RD;
    end else begin
      state <= nextState;
      cmdQ  <= cmdNext;
    end
  end
endmodule

// File: rtl/coh_snoop_ctrl.sv
`timescale 1ns/1ps
module coh_snoop_ctrl
  import coh_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int NUM_LINES  = 16,
  localparam int LINE_W = ADDR_W - $clog2(LINE_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuValid,
  input  logic              cpuWrite,
  input  logic [ADDR_W-1:0] cpuAddr,
  output logic              cpuReady,
  output logic              busReq,
  input  logic              busGnt,
  output logic              busActive,
  output logic [1:0]        busCmd,
  output logic [LINE_W-1:0] busAddr,
  input  logic              busDone,
  input  logic              snpValid,
  input  logic [1:0]        snpCmd,
  input  logic [LINE_W-1:0] snpLine,
  output logic              snpDirty
);
  ctrlStrobe_t strobe;
  lineState_e  lkState;
  lineState_e  vicState;
  busCmd_e     ctlCmd;

  coh_control uCtl (
    .clk      (clk),
    .rstN     (rstN),
    .cpuValid (cpuValid),
    .cpuWrite (cpuWrite),
    .lkState  (lkState),
    .vicState (vicState),
    .busGnt   (busGnt),
    .busDone  (busDone),
    .cpuReady (cpuReady),
    .busReq   (busReq),
    .busActive(busActive),
    .busCmd   (ctlCmd),
    .strobe   (strobe)
  );

  coh_datapath #(
    .ADDR_W    (ADDR_W),
    .LINE_BYTES(LINE_BYTES),
    .NUM_LINES (NUM_LINES)
  ) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .cpuAddr (cpuAddr),
    .strobe  (strobe),
    .snpValid(snpValid),
    .snpCmd  (snpCmd),
    .snpLine (snpLine),
    .lkState (lkState),
    .vicState(vicState),
    .busLine (busAddr),
    .snpDirty(snpDirty)
  );

  assign busCmd = ctlCmd;
endmodule

// File: rtl/coh_checker.sv
`timescale 1ns/1ps
module coh_checker #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32,
  localparam int LINE_W = ADDR_W - $clog2(LINE_BYTES)
) (
  input logic              clk,
  input logic              rstN,
  input logic              cpuValid,
  input logic              cpuReady,
  input logic              busReq,
  input logic              busGnt,
  input logic              busActive,
  input logic [1:0]        busCmd,
  input logic [LINE_W-1:0] busAddr,
  input logic              busDone,
  input logic              snpValid,
  input logic [1:0]        snpCmd,
  input logic              snpDirty
);
  p_ready_needs_valid_r2: assert property (@(posedge clk) disable iff (!rstN)
    cpuReady |-> cpuValid);

  p_gnt_before_active_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busActive) |-> $past(busGnt));

  p_hold_active_r6: assert property (@(posedge clk) disable iff (!rstN)
    (busActive && !busDone) |=> busActive);

  p_stable_txn_r6: assert property (@(posedge clk) disable iff (!rstN)
    (busActive && !busDone) |=> ($stable(busCmd) && $stable(busAddr)));

  p_req_while_active_r6: assert property (@(posedge clk) disable iff (!rstN)
    busActive |-> busReq);

  p_dirty_cause_r7: assert property (@(posedge clk) disable iff (!rstN)
    snpDirty |-> ($past(snpValid) && (($past(snpCmd) == 2'd0) || ($past(snpCmd) == 2'd1))));

  p_wb_release_r10: assert property (@(posedge clk) disable iff (!rstN)
    (busActive && (busCmd == 2'd3) && busDone) |=> !busActive);

  p_wb_snoop_quiet_r13: assert property (@(posedge clk) disable iff (!rstN)
    (snpValid && (snpCmd == 2'd3)) |=> !snpDirty);
endmodule

bind coh_snoop_ctrl coh_checker #(
  .ADDR_W    (ADDR_W),
  .LINE_BYTES(LINE_BYTES)
) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .cpuValid (cpuValid),
  .cpuReady (cpuReady),
  .busReq   (busReq),
  .busGnt   (busGnt),
  .busActive(busActive),
  .busCmd   (busCmd),
  .busAddr  (busAddr),
  .busDone  (busDone),
  .snpValid (snpValid),
  .snpCmd   (snpCmd),
  .snpDirty (snpDirty)
);

// File: tb/sim_coh_snoop_ctrl.sv
`timescale 1ns/1ps
module sim_coh_snoop_ctrl;
  localparam int ADDR_W = 32;
  localparam int LINE_W = 27;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              cpuValid = 1'b0;
  logic              cpuWrite = 1'b0;
  logic [ADDR_W-1:0] cpuAddr = '0;
  logic              cpuReady;
  logic              busReq;
  logic              busGnt = 1'b0;
  logic              busActive;
  logic [1:0]        busCmd;
  logic [LINE_W-1:0] busAddr;
  logic              busDone = 1'b0;
  logic              snpValid = 1'b0;
  logic [1:0]        snpCmd = '0;
  logic [LINE_W-1:0] snpLine = '0;
  logic              snpDirty;

  always #2.5 clk = ~clk;

  coh_snoop_ctrl u0 (
    .clk(clk), .rstN(rstN), .cpuValid(cpuValid), .cpuWrite(cpuWrite),
    .cpuAddr(cpuAddr), .cpuReady(cpuReady), .busReq(busReq), .busGnt(busGnt),
    .busActive(busActive), .busCmd(busCmd), .busAddr(busAddr), .busDone(busDone),
    .snpValid(snpValid), .snpCmd(snpCmd), .snpLine(snpLine), .snpDirty(snpDirty)
  );

  typedef struct {
    logic [1:0]        cmd;
    logic [LINE_W-1:0] line;
    string             req;
  } txn_t;

  txn_t expQ[$];
  int   checks = 0;
  int   errors = 0;
  logic gntBlock = 1'b0;

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] mkAddr(input int tag, input int idx);
    return (32'(tag) << 9) | (32'(idx) << 5);
  endfunction

  task automatic expectTx(input logic [1:0] cmd, input logic [31:0] addr, input string req);
    txn_t t;
    t.cmd  = cmd;
    t.line = addr[31:5];
    t.req  = req;
    expQ.push_back(t);
  endtask

  task automatic chkQ(input string req);
    check(req, expQ.size(), 0);
  endtask

  // bus arbiter, memory responder and scoreboard monitor
  bit inTx = 0;
  int txCnt = 0;
  always @(negedge clk) begin
    busDone = 1'b0;
    if (busActive && !inTx) begin
      inTx  = 1;
      txCnt = 0;
      if (expQ.size() == 0) begin
        checks++;
        errors++;
        $display("FAIL R6: unexpected transaction cmd %0d line %0h, expected none", busCmd, busAddr);
      end else begin
        txn_t t;
        t = expQ.pop_front();
        check(t.req, busCmd, t.cmd);
        check(t.req, busAddr, t.line);
      end
    end else if (busActive && inTx) begin
      txCnt++;
      if (txCnt == 2) begin
        busDone = 1'b1;
        inTx    = 0;
      end
    end
    busGnt = busReq && !busActive && !gntBlock && rstN;
  end

  task automatic cpuOp(input bit wr, input logic [31:0] addr, output int waits);
    @(negedge clk);
    cpuValid = 1'b1;
    cpuWrite = wr;
    cpuAddr  = addr;
    waits    = 0;
    #1;
    while (!cpuReady) begin
      @(negedge clk);
      #1;
      waits++;
    end
    @(posedge clk);
    #1;
    cpuValid = 1'b0;
    cpuWrite = 1'b0;
  endtask

  task automatic snoop(input logic [1:0] cmd, input logic [31:0] addr, input bit expDirty,
                       input string req);
    @(negedge clk);
    snpValid = 1'b1;
    snpCmd   = cmd;
    snpLine  = addr[31:5];
    @(posedge clk);
    #1;
    snpValid = 1'b0;
    check(req, snpDirty, expDirty);
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int w;
    logic [31:0] lineA, lineB, lineC, lineD, lineE, lineX;
    lineA = mkAddr(1, 0);
    lineB = mkAddr(1, 1);
    lineC = mkAddr(2, 0);
    lineD = mkAddr(3, 2);
    lineE = mkAddr(4, 2);
    lineX = mkAddr(5, 0);

    repeat (3) @(posedge clk);
    #1;
    // R1: quiet outputs while reset is held
    check("R1 cpuReady", cpuReady, 0);
    check("R1 busReq", busReq, 0);
    check("R1 busActive", busActive, 0);
    check("R1 snpDirty", snpDirty, 0);
    @(negedge clk);
    rstN = 1'b1;

    // R1/R3: first read misses, fills Shared
    expectTx(2'd0, lineA, "R3");
    cpuOp(0, lineA, w);
    check("R1 miss after reset", (w > 0), 1);
    chkQ("R3");
    cpuOp(0, lineA, w);
    check("R2 read hit Shared", w, 0);

    // R5: write to Shared upgrades with invalidate
    expectTx(2'd2, lineA, "R5");
    cpuOp(1, lineA, w);
    chkQ("R5");
    cpuOp(1, lineA, w);
    check("R5 write hit Modified", w, 0);
    cpuOp(0, lineA, w);
    check("R2 read hit Modified", w, 0);

    // R4: write to Invalid reads for ownership
    expectTx(2'd1, lineB, "R4");
    cpuOp(1, lineB, w);
    chkQ("R4");
    cpuOp(1, lineB, w);
    check("R4 line now Modified", w, 0);

    // R7: snoop read on Modified -> intervene, becomes Shared
    snoop(2'd0, lineB, 1, "R7 dirty");
    cpuOp(0, lineB, w);
    check("R7 still readable", w, 0);
    expectTx(2'd2, lineB, "R7");
    cpuOp(1, lineB, w);
    chkQ("R7");

    // R8: snoop read-for-ownership on Modified -> intervene, Invalid
    snoop(2'd1, lineB, 1, "R8 dirty");
    expectTx(2'd0, lineB, "R8");
    cpuOp(0, lineB, w);
    chkQ("R8");

    // R9: snoops on Shared
    snoop(2'd0, lineB, 0, "R9 read on Shared");
    cpuOp(0, lineB, w);
    check("R9 Shared kept", w, 0);
    snoop(2'd2, lineB, 0, "R9 invalidate on Shared");
    expectTx(2'd0, lineB, "R9");
    cpuOp(0, lineB, w);
    chkQ("R9");
    snoop(2'd1, lineB, 0, "R9 rfo on Shared");
    expectTx(2'd0, lineB, "R9");
    cpuOp(0, lineB, w);
    chkQ("R9");

    // R13: tag mismatch and write-back snoops have no effect
    snoop(2'd1, lineX, 0, "R13 mismatch");
    cpuOp(1, lineA, w);
    check("R13 Modified kept after mismatch", w, 0);
    snoop(2'd3, lineA, 0, "R13 wb snoop");
    cpuOp(1, lineA, w);
    check("R13 Modified kept after wb snoop", w, 0);
    chkQ("R13");

    // R10: dirty victim written back before refill
    expectTx(2'd3, lineA, "R10");
    expectTx(2'd0, lineC, "R10");
    cpuOp(0, lineC, w);
    chkQ("R10");
    expectTx(2'd0, lineA, "R10");
    cpuOp(0, lineA, w);
    chkQ("R10");

    // R11: upgrade loses line while grant is withheld
    expectTx(2'd0, lineD, "R11");
    cpuOp(0, lineD, w);
    chkQ("R11");
    expectTx(2'd1, lineD, "R11");
    gntBlock = 1'b1;
    fork
      cpuOp(1, lineD, w);
      begin
        repeat (3) @(negedge clk);
        #1;
        check("R6 request held", busReq, 1);
        check("R6 no grant no transaction", busActive, 0);
        snoop(2'd2, lineD, 0, "R11 snoop");
        @(negedge clk);
        #1;
        gntBlock = 1'b0;
      end
    join
    chkQ("R11");
    cpuOp(1, lineD, w);
    check("R11 line Modified", w, 0);

    // R12: dirty victim downgraded by snoop before write-back grant
    expectTx(2'd0, lineE, "R12");
    gntBlock = 1'b1;
    fork
      cpuOp(0, lineE, w);
      begin
        repeat (3) @(negedge clk);
        #1;
        snoop(2'd0, lineD, 1, "R12 snoop dirty");
        @(negedge clk);
        #1;
        gntBlock = 1'b0;
      end
    join
    chkQ("R12");
    cpuOp(0, lineE, w);
    check("R12 refill Shared", w, 0);

    repeat (4) @(negedge clk);
    chkQ("R6 end");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule